// File: doc/BRIEF.md
# Latched Parallel-In Serial-Out Shifter

This block turns a word of parallel bits into a serial bit stream through two storage stages. A holding register captures the parallel word when its capture strobe is pulsed. A shift chain of the same width then takes its contents from the holding register, or moves one bit per shift strobe toward its far end. The far end drives the serial output. The stage nearest the serial input is stage 0, and parallel bit i feeds stage i. The far end is stage W-1.

A single mode input selects what the shift chain does. While mode is low, the chain copies the holding register on every system clock, and the shift strobe and serial input have no effect. While mode is high, each shift strobe moves the chain by one stage and takes in the serial input bit. Both strobes are one-cycle enables sampled on the one system clock.

An active-low clear empties the shift chain at once, without waiting for a clock edge. Its release is resynchronised to the clock. The clear never touches the holding register, so a word captured before a clear can still be loaded and sent after it.

Top module: `pso_latched_shifter`

## Requirements
- R1: When `cap_stb` is high at a clock edge, the holding register takes the value of `par_in`. A later load followed by shifting presents that value at `ser_out`, most significant stage first.
- R2: When `cap_stb` is low at a clock edge, the holding register keeps its value whatever `par_in` does.
- R3: When `mode` is 1 (shift) and `shift_stb` is high at a clock edge, stage 0 takes `ser_in` and stage i takes the old value of stage i-1. Bits inserted in sequence therefore leave `ser_out` in the same sequence, W shifts later.
- R4: When `mode` is 1 and `shift_stb` is low at a clock edge, the shift chain keeps its value whatever `ser_in` does.
- R5: When `mode` is 0 (load), the shift chain is loaded from the holding register at every clock edge, with parallel bit i going to stage i. During load, `shift_stb` and `ser_in` are ignored, and the chain follows any later capture one edge after that capture.
- R6: When `cap_stb` is high and `mode` is 0 at the same edge, the shift chain receives the holding register value from before that edge's capture.
- R7: While `clear_n` is low, every stage of the shift chain is 0. This takes effect immediately, without a clock edge, and overrides load and shift.
- R8: After `clear_n` rises, the shift chain stays at 0 for SYNC_STAGES clock edges. The first load or shift takes effect on edge SYNC_STAGES+1.
- R9: A clear leaves the holding register unchanged.
- R10: `ser_out` always equals stage W-1 of the shift chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| clear_n | input | 1 | Active-low clear of the shift chain; asserts without a clock, releases on the clock |
| par_in | input | W | Parallel word; bit i feeds stage i |
| cap_stb | input | 1 | One-cycle strobe that captures `par_in` into the holding register |
| shift_stb | input | 1 | One-cycle strobe that advances the shift chain when `mode` is 1 |
| mode | input | 1 | 0 = load from the holding register every clock, 1 = serial shift |
| ser_in | input | 1 | Serial bit entering stage 0 on a shift |
| ser_out | output | 1 | Value of stage W-1 |

## Verification
The only window onto the design is `ser_out`. A bad bit in the holding register or in any stage stays hidden until enough shifts or a load carry it to the last stage. That takes at most W shift strobes after a load, or one edge after a wrong reload. Every test therefore reads back a whole word, so that a corrupted stage, a stage taken from the wrong neighbour or a stale capture shows up within one readout of W cycles. The clear and its release are checked edge by edge against `ser_out`, so a release one cycle early or late shows up on the exact edge where it happens.

// File: rtl/pso_pkg.sv
package pso_pkg;

    localparam int DEFAULT_WIDTH = 8;
    localparam int DEFAULT_SYNC  = 2;

    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } pso_mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_SHIFT = 2'd2
    } pso_act_e;

    typedef struct packed {
        pso_act_e act;
        logic     ser_bit;
    } pso_step_t;

    // Load wins over shift; clear is applied by the register reset itself.
    function automatic pso_act_e pick_action(input logic mode, input logic shift_stb);
        pso_act_e a;
        if (mode == MODE_LOAD)
            a = ACT_LOAD;
        else if (shift_stb)
            a = ACT_SHIFT;
        else
            a = ACT_HOLD;
        return a;
    endfunction

endpackage

// File: rtl/pso_input_latch.sv
module pso_input_latch #(
    parameter int W = pso_pkg::DEFAULT_WIDTH
) (
    input  logic         clk,
    input  logic         cap_stb,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    // Holding register: deliberately outside the clear domain.
    logic [W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (cap_stb)
            hold_q <= d_in;
    end

    assign q_out = hold_q;
endmodule

// File: rtl/pso_release_sync.sv
module pso_release_sync #(
    parameter int STAGES = pso_pkg::DEFAULT_SYNC
) (
    input  logic clk,
    input  logic clear_n,
    output logic rel_n
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sync_q;

    // Assert without a clock, release through STAGES flops.
    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end

    assign rel_n = sync_q[TOP];
endmodule

// File: rtl/pso_shift_chain.sv
module pso_shift_chain #(
    parameter int W = pso_pkg::DEFAULT_WIDTH
) (
    input  logic               clk,
    input  logic               rel_n,
    input  logic               clear_n,
    input  pso_pkg::pso_step_t step,
    input  logic [W-1:0]       par_in,
    output logic [W-1:0]       stages
);
    import pso_pkg::*;

    // The chain is held empty while either the raw clear or the
    // synchronised release is low, so clearing needs no clock edge.
    logic chain_rst_n;
    assign chain_rst_n = clear_n & rel_n;

    for (genvar i = 0; i < W; i++) begin : g_stage
        logic from_prev;
        logic stage_q;

        if (i == 0) begin : g_head
            assign from_prev = step.ser_bit;
        end else begin : g_body
            assign from_prev = stages[i-1];
        end

        always_ff @(posedge clk or negedge chain_rst_n) begin
            if (!chain_rst_n)
                stage_q <= 1'b0;
            else begin
                case (step.act)
                    ACT_LOAD:  stage_q <= par_in[i];
                    ACT_SHIFT: stage_q <= from_prev;
                    default:   stage_q <= stage_q;
                endcase
            end
        end

        assign stages[i] = stage_q;
    end
endmodule

// File: rtl/pso_latched_shifter.sv
module pso_latched_shifter #(
    parameter int W           = pso_pkg::DEFAULT_WIDTH,
    parameter int SYNC_STAGES = pso_pkg::DEFAULT_SYNC
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic [W-1:0] par_in,
    input  logic         cap_stb,
    input  logic         shift_stb,
    input  logic         mode,
    input  logic         ser_in,
    output logic         ser_out
);
    import pso_pkg::*;

    localparam int LAST = W - 1;

    logic [W-1:0] latch_q;
    logic [W-1:0] sr_q;
    logic         rel_n;
    pso_step_t    step;

    assign step.act     = pick_action(mode, shift_stb);
    assign step.ser_bit = ser_in;

    pso_input_latch #(.W(W)) u_latch (
        .clk     (clk),
        .cap_stb (cap_stb),
        .d_in    (par_in),
        .q_out   (latch_q)
    );

    pso_release_sync #(.STAGES(SYNC_STAGES)) u_rel (
        .clk     (clk),
        .clear_n (clear_n),
        .rel_n   (rel_n)
    );

    pso_shift_chain #(.W(W)) u_chain (
        .clk     (clk),
        .rel_n   (rel_n),
        .clear_n (clear_n),
        .step    (step),
        .par_in  (latch_q),
        .stages  (sr_q)
    );

    assign ser_out = sr_q[LAST];
endmodule

// File: rtl/pso_latched_shifter_chk.sv
module pso_latched_shifter_chk #(
    parameter int W = pso_pkg::DEFAULT_WIDTH
) (
    input logic         clk,
    input logic         rel_n,
    input logic         mode,
    input logic         shift_stb,
    input logic         ser_in,
    input logic         cap_stb,
    input logic [W-1:0] par_in,
    input logic [W-1:0] latch_q,
    input logic [W-1:0] sr_q
);
    AST_CLEAR_EMPTY: assert property (@(posedge clk)
        (rel_n === 1'b0) |-> (sr_q == '0)); // R7

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rel_n)
        cap_stb |=> (latch_q == $past(par_in))); // R1

    AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rel_n)
        !cap_stb |=> $stable(latch_q)); // R2

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rel_n)
        (mode && shift_stb) |=> (sr_q == {$past(sr_q[W-2:0]), $past(ser_in)})); // R3

    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rel_n)
        (mode && !shift_stb) |=> $stable(sr_q)); // R4

    AST_LOAD_TRACK: assert property (@(posedge clk) disable iff (!rel_n)
        !mode |=> (sr_q == $past(latch_q))); // R5 R6
endmodule

bind pso_latched_shifter pso_latched_shifter_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rel_n     (rel_n),
    .mode      (mode),
    .shift_stb (shift_stb),
    .ser_in    (ser_in),
    .cap_stb   (cap_stb),
    .par_in    (par_in),
    .latch_q   (latch_q),
    .sr_q      (sr_q)
);

// File: tb/pso_latched_shifter_tb.sv
module pso_latched_shifter_tb;
    localparam int W = 8;
    localparam int SYNC = 2;

    logic         clk = 1'b0;
    logic         clear_n;
    logic [W-1:0] par_in;
    logic         cap_stb;
    logic         shift_stb;
    logic         mode;
    logic         ser_in;
    logic         ser_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pso_latched_shifter #(.W(W), .SYNC_STAGES(SYNC)) u_dut (
        .clk       (clk),
        .clear_n   (clear_n),
        .par_in    (par_in),
        .cap_stb   (cap_stb),
        .shift_stb (shift_stb),
        .mode      (mode),
        .ser_in    (ser_in),
        .ser_out   (ser_out)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: ser_out=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic capture(logic [W-1:0] v);
        par_in  = v;
        cap_stb = 1'b1;
        tick();
        cap_stb = 1'b0;
    endtask

    task automatic load_once();
        mode = 1'b0;
        tick();
        mode = 1'b1;
    endtask

    task automatic read_word(string req, logic [W-1:0] exp);
        mode   = 1'b1;
        ser_in = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            check_bit(req, ser_out, exp[i]);
            shift_stb = 1'b1;
            tick();
            shift_stb = 1'b0;
        end
    endtask

    task automatic t_reset_state();
        read_word("R7 chain empty after clear", '0);
    endtask

    task automatic t_load_shift();
        capture(8'hA5); load_once(); read_word("R1 R10 load A5", 8'hA5);
        capture(8'h3C); load_once(); read_word("R1 R10 load 3C", 8'h3C);
    endtask

    task automatic t_serial_in();
        logic [W-1:0] v = 8'h96;
        mode = 1'b1;
        for (int k = W - 1; k >= 0; k--) begin
            ser_in    = v[k];
            shift_stb = 1'b1;
            tick();
        end
        shift_stb = 1'b0;
        read_word("R3 serial in order", v);
    endtask

    task automatic t_hold();
        capture(8'h81); load_once();
        for (int k = 0; k < 5; k++) begin
            ser_in = k[0];
            tick();
            check_bit("R4 idle hold", ser_out, 1'b1);
        end
        read_word("R4 idle hold word", 8'h81);
    endtask

    task automatic t_latch_keep();
        capture(8'h4E);
        par_in = 8'hFF;
        for (int k = 0; k < 3; k++) tick();
        load_once();
        read_word("R2 latch keeps without strobe", 8'h4E);
    endtask

    task automatic t_load_mode();
        capture(8'hF0);
        mode      = 1'b0;
        shift_stb = 1'b1;
        ser_in    = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick();
            check_bit("R5 shift ignored in load", ser_out, 1'b1);
        end
        shift_stb = 1'b0;
        read_word("R5 load ignores strobe", 8'hF0);
        mode = 1'b0;
        capture(8'h0F);
        check_bit("R5 old value on capture edge", ser_out, 1'b1);
        tick();
        check_bit("R5 follows latch next edge", ser_out, 1'b0);
        read_word("R5 tracked word", 8'h0F);
    endtask

    task automatic t_same_cycle();
        mode = 1'b1;
        capture(8'h33);
        mode    = 1'b0;
        par_in  = 8'hCC;
        cap_stb = 1'b1;
        tick();
        cap_stb = 1'b0;
        mode    = 1'b1;
        read_word("R6 pre-capture value", 8'h33);
        load_once();
        read_word("R6 new capture later", 8'hCC);
    endtask

    task automatic t_clear();
        capture(8'hC3); load_once();
        check_bit("R7 before clear", ser_out, 1'b1);
        #3 clear_n = 1'b0;
        #1 check_bit("R7 immediate clear", ser_out, 1'b0);
        @(negedge clk);
        mode = 1'b0;
        for (int k = 0; k < 3; k++) begin
            tick();
            check_bit("R7 clear beats load", ser_out, 1'b0);
        end
        clear_n = 1'b1;
        for (int k = 0; k < SYNC; k++) begin
            tick();
            check_bit("R8 held during release", ser_out, 1'b0);
        end
        tick();
        check_bit("R8 resume edge", ser_out, 1'b1);
        read_word("R9 latch kept over clear", 8'hC3);
    endtask

    initial begin
        #(20 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        clear_n   = 1'b0;
        par_in    = '0;
        cap_stb   = 1'b1;
        shift_stb = 1'b0;
        mode      = 1'b1;
        ser_in    = 1'b0;
        tick();
        cap_stb = 1'b0;
        check_bit("R7 reset output", ser_out, 1'b0);
        clear_n = 1'b1;
        for (int k = 0; k <= SYNC; k++) tick();
        t_reset_state();
        t_load_shift();
        t_serial_in();
        t_hold();
        t_latch_keep();
        t_load_mode();
        t_same_cycle();
        t_clear();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule